// File: doc/BRIEF.md
# Dual Product Engine on Shared Arithmetic Units

The block works out two 8-bit results from five 8-bit operands: `f = e*(a+b)` and `g = (a+b)*(c+d)`. It has a single adder and a single multiplier, and both are shared over time. Four working registers hold the values between steps, and each register takes its next value through its own small selector. A controller walks through a fixed series of steps. It loads the first two operands, forms `a+b` while it brings in the others, then forms `c+d` while the multiplier makes `f`, and finally makes `g`. The sum `a+b` is formed once and feeds both products.

A caller pulses `start` while the engine is idle. It must present `a` and `b` in the first busy cycle and `c`, `d` and `e` in the second. It then waits for `done`. All arithmetic keeps only the low 8 bits: sums and products wrap modulo 256. The results stay on `f_out` and `g_out` until a later start overwrites the working registers. Per-step controls come from a table indexed by the step. A parameter chooses a precomputed table or direct decode.

Top module: `dual_product_engine`

## Requirements
- R1: After reset `done`, `f_out` and `g_out` are 0, and the engine stays idle with `done` low for as long as `start` is low.
- R2: When `done` is high, `f_out` equals `(e*((a+b) mod 256)) mod 256`.
- R3: When `done` is high, `g_out` equals `(((a+b) mod 256)*((c+d) mod 256)) mod 256`. The sum `a+b` is computed once and that stored value is the operand of both products.
- R4: If `start` is high at the clock edge that finds the engine idle, `done` is high for exactly one cycle. That cycle is the fifth cycle after that edge, and `done` is low in the four cycles before it.
- R5: `start` is ignored while the engine is busy, including the cycle in which `done` is high. It causes no restart, no extra `done` pulse and no change to the results.
- R6: After the `done` cycle, `f_out` and `g_out` keep their values until the next accepted start.
- R7: `a` and `b` are read only in the first cycle after the start edge, and `c`, `d` and `e` only in the second. Any value on these inputs at other times has no effect on the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a computation, taken only when idle |
| op_a | input | 8 | Operand a |
| op_b | input | 8 | Operand b |
| op_c | input | 8 | Operand c |
| op_d | input | 8 | Operand d |
| op_e | input | 8 | Operand e |
| done | output | 1 | One-cycle flag: results are valid |
| f_out | output | 8 | Result e*(a+b), modulo 256 |
| g_out | output | 8 | Result (a+b)*(c+d), modulo 256 |

## Verification
The hardest case to reach from the ports is the one where the operand inputs carry values that must not be used. A wrong read window would go unseen as long as the inputs stay constant for the whole run. The stimulus therefore replaces `a` and `b` with fresh random values once their read cycle has passed, and does the same to `c`, `d` and `e` one cycle later. It also raises `start` in the middle of the run and during the `done` cycle, then checks that no second run starts and the results do not change. Operand values near 255 force both sums and both products to wrap.

// File: rtl/dpe_pkg.sv
`timescale 1ns/1ps
package dpe_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_LOAD  = 3'd1,
      ST_SUM1  = 3'd2,
      ST_SUM2  = 3'd3,
      ST_PROD2 = 3'd4,
      ST_FIN   = 3'd5
   } step_e;

   localparam int N_STEPS  = 6;
   localparam int N_REGS   = 4;
   localparam int SEL_W    = 2;
   localparam int TBL_SIZE = 1 << $bits(step_e);

   // register indices (0..3 stand for the four working registers)
   localparam int RI_CD  = 0;   // c, later c+d
   localparam int RI_AB  = 1;   // a+b, later g
   localparam int RI_OPA = 2;   // a, later d
   localparam int RI_OPB = 3;   // b, then e, then f

   // selector codes
   localparam logic [SEL_W-1:0] SEL_IN0 = 2'd0;
   localparam logic [SEL_W-1:0] SEL_IN1 = 2'd1;
   localparam logic [SEL_W-1:0] SEL_IN2 = 2'd2;

   typedef struct packed {
      logic                             wait_go;
      logic [N_REGS-1:0]                ld;
      logic [N_REGS-1:0][SEL_W-1:0]     sel;
      logic                             add_pick;
      logic                             mul_pick;
      logic                             fin;
      step_e                            nxt;
   } ctl_t;

   function automatic ctl_t ctl_of(step_e s);
      ctl_t w;
      w = '0;
      case (s)
         ST_IDLE: begin
            w.wait_go = 1'b1;
            w.nxt     = ST_LOAD;
         end
         ST_LOAD: begin
            w.ld[RI_OPA]  = 1'b1; w.sel[RI_OPA] = SEL_IN0;   // a
            w.ld[RI_OPB]  = 1'b1; w.sel[RI_OPB] = SEL_IN0;   // b
            w.nxt         = ST_SUM1;
         end
         ST_SUM1: begin
            w.add_pick    = 1'b0;                            // a + b
            w.ld[RI_AB]   = 1'b1; w.sel[RI_AB]  = SEL_IN0;   // sum
            w.ld[RI_CD]   = 1'b1; w.sel[RI_CD]  = SEL_IN0;   // c
            w.ld[RI_OPA]  = 1'b1; w.sel[RI_OPA] = SEL_IN1;   // d
            w.ld[RI_OPB]  = 1'b1; w.sel[RI_OPB] = SEL_IN1;   // e
            w.nxt         = ST_SUM2;
         end
         ST_SUM2: begin
            w.add_pick    = 1'b1;                            // c + d
            w.ld[RI_CD]   = 1'b1; w.sel[RI_CD]  = SEL_IN1;   // sum
            w.mul_pick    = 1'b0;                            // (a+b) * e
            w.ld[RI_OPB]  = 1'b1; w.sel[RI_OPB] = SEL_IN2;   // product
            w.nxt         = ST_PROD2;
         end
         ST_PROD2: begin
            w.mul_pick    = 1'b1;                            // (a+b) * (c+d)
            w.ld[RI_AB]   = 1'b1; w.sel[RI_AB]  = SEL_IN1;   // product
            w.nxt         = ST_FIN;
         end
         ST_FIN: begin
            w.fin         = 1'b1;
            w.nxt         = ST_IDLE;
         end
         default: w.nxt   = ST_IDLE;
      endcase
      return w;
   endfunction

endpackage

// File: rtl/dpe_ctrl.sv
`timescale 1ns/1ps
module dpe_ctrl
   import dpe_pkg::*;
#(
   parameter bit ROM_CTRL = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   output logic [N_REGS-1:0]             ld,
   output logic [N_REGS-1:0][SEL_W-1:0]  sel,
   output logic                          add_pick,
   output logic                          mul_pick,
   output logic                          fin
);

   step_e state_q, state_d;
   ctl_t  word;

   if (N_STEPS > TBL_SIZE) begin : g_bad_tbl
      $error("dpe_ctrl: step table too small for the step count");
   end

   if (ROM_CTRL) begin : g_rom
      ctl_t tbl [TBL_SIZE];
      always_comb begin
         for (int i = 0; i < TBL_SIZE; i++) begin
            tbl[i] = ctl_of(step_e'(i));
         end
      end
      assign word = tbl[state_q];
   end else begin : g_decode
      assign word = ctl_of(state_q);
   end

   always_comb begin
      if (word.wait_go) state_d = start ? word.nxt : ST_IDLE;
      else              state_d = word.nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign ld       = word.ld;
   assign sel      = word.sel;
   assign add_pick = word.add_pick;
   assign mul_pick = word.mul_pick;
   assign fin      = word.fin;

   // R1: no start keeps the engine idle
   a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !start) |=> (state_q == ST_IDLE));

   // R5: the first load step is entered only from idle
   a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |=> (state_q != ST_LOAD));

   // R4: finish flag lasts one cycle
   a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !fin);

endmodule

// File: rtl/dpe_regs.sv
`timescale 1ns/1ps
module dpe_regs
   import dpe_pkg::*;
#(
   parameter int W = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N_REGS-1:0]             ld,
   input  logic [N_REGS-1:0][SEL_W-1:0]  sel,
   input  logic [W-1:0]                  op_a,
   input  logic [W-1:0]                  op_b,
   input  logic [W-1:0]                  op_c,
   input  logic [W-1:0]                  op_d,
   input  logic [W-1:0]                  op_e,
   input  logic [W-1:0]                  sum,
   input  logic [W-1:0]                  prod,
   output logic [W-1:0]                  q [N_REGS]
);

   localparam int N_CAND = 1 << SEL_W;

   logic [N_REGS-1:0][N_CAND-1:0][W-1:0] cand;

   always_comb begin
      cand = '0;
      cand[RI_CD][0]  = op_c;
      cand[RI_CD][1]  = sum;
      cand[RI_AB][0]  = sum;
      cand[RI_AB][1]  = prod;
      cand[RI_OPA][0] = op_a;
      cand[RI_OPA][1] = op_d;
      cand[RI_OPB][0] = op_b;
      cand[RI_OPB][1] = op_e;
      cand[RI_OPB][2] = prod;
   end

   for (genvar gi = 0; gi < N_REGS; gi++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q[gi] <= '0;
         else if (ld[gi]) q[gi] <= cand[gi][sel[gi]];
      end
      if (gi != RI_OPB) begin : g_two_way
         // R3: two-way selectors never see the third code
         a_r3_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
            ld[gi] |-> (sel[gi] < 2'd2));
      end
   end

   // R3: the stored a+b is the one reused by the second product
   a_r3_sum_reused: assert property (@(posedge clk) disable iff (!rst_n)
      (ld[RI_AB] && sel[RI_AB] == 2'd1) |->
         (!$past(ld[RI_AB]) && $past(ld[RI_AB] && sel[RI_AB] == 2'd0, 2)));

endmodule

// File: rtl/dpe_units.sv
`timescale 1ns/1ps
module dpe_units
   import dpe_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] r [N_REGS],
   input  logic         add_pick,
   input  logic         mul_pick,
   output logic [W-1:0] sum,
   output logic [W-1:0] prod
);

   logic [W-1:0] add_x, add_y, mul_x, mul_y;

   assign add_x = add_pick ? r[RI_CD] : r[RI_OPB];
   assign add_y = r[RI_OPA];
   assign mul_x = r[RI_AB];
   assign mul_y = mul_pick ? r[RI_CD] : r[RI_OPB];

   assign sum  = add_x + add_y;
   assign prod = mul_x * mul_y;

endmodule

// File: rtl/dual_product_engine.sv
`timescale 1ns/1ps
module dual_product_engine
   import dpe_pkg::*;
#(
   parameter int W        = 8,
   parameter bit ROM_CTRL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   input  logic [W-1:0] op_c,
   input  logic [W-1:0] op_d,
   input  logic [W-1:0] op_e,
   output logic         done,
   output logic [W-1:0] f_out,
   output logic [W-1:0] g_out
);

   if (W < 2) begin : g_bad_w
      $error("dual_product_engine: W must be at least 2");
   end

   logic [N_REGS-1:0]            ld;
   logic [N_REGS-1:0][SEL_W-1:0] sel;
   logic                         add_pick, mul_pick;
   logic [W-1:0]                 sum, prod;
   logic [W-1:0]                 rq [N_REGS];

   dpe_ctrl #(.ROM_CTRL(ROM_CTRL)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .ld(ld), .sel(sel), .add_pick(add_pick), .mul_pick(mul_pick),
      .fin(done)
   );

   dpe_regs #(.W(W)) u_regs (
      .clk(clk), .rst_n(rst_n), .ld(ld), .sel(sel),
      .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d), .op_e(op_e),
      .sum(sum), .prod(prod), .q(rq)
   );

   dpe_units #(.W(W)) u_units (
      .r(rq), .add_pick(add_pick), .mul_pick(mul_pick),
      .sum(sum), .prod(prod)
   );

   assign f_out = rq[RI_OPB];
   assign g_out = rq[RI_AB];

   // R6: f is settled one step before done and does not move in the done cycle
   a_r6_f_stable: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $stable(f_out));

endmodule

// File: tb/dual_product_engine_test.sv
`timescale 1ns/1ps
module dual_product_engine_test;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] a = '0, b = '0, c = '0, d = '0, e = '0;
   logic         done;
   logic [W-1:0] f, g;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   dual_product_engine #(.W(W)) uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .op_a(a), .op_b(b), .op_c(c), .op_d(d), .op_e(e),
      .done(done), .f_out(f), .g_out(g)
   );

   task automatic check(string req, string what, int act, int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int ref_f(int ia, int ib, int ie);
      return (((ia + ib) % 256) * ie) % 256;
   endfunction

   function automatic int ref_g(int ia, int ib, int ic, int id);
      return (((ia + ib) % 256) * ((ic + id) % 256)) % 256;
   endfunction

   task automatic run(input logic [W-1:0] ia, ib, ic, id, ie,
                      input bit junk, input bit poke);
      int ef, eg;
      ef = ref_f(ia, ib, ie);
      eg = ref_g(ia, ib, ic, id);
      @(negedge clk);
      start = 1'b1; a = ia; b = ib; c = ic; d = id; e = ie;
      @(posedge clk);                 // start taken
      @(negedge clk); start = poke;   // first busy cycle: a, b read
      @(posedge clk);
      @(negedge clk);                 // second busy cycle: c, d, e read
      start = poke;
      if (junk) begin a = W'($urandom); b = W'($urandom); end  // R7
      check("R4", "done early c2", int'(done), 0);
      @(posedge clk);
      @(negedge clk);
      start = poke;
      if (junk) begin c = W'($urandom); d = W'($urandom); e = W'($urandom); end  // R7
      check("R4", "done early c3", int'(done), 0);
      @(posedge clk);
      @(negedge clk); start = poke;
      check("R4", "done early c4", int'(done), 0);
      @(posedge clk);
      @(negedge clk);                 // fifth cycle
      check("R4", "done", int'(done), 1);
      check("R2", "f", int'(f), ef);
      check("R3", "g", int'(g), eg);
      start = poke;                   // R5: start in the done cycle
      @(posedge clk);
      @(negedge clk); start = 1'b0;
      check("R4", "done pulse end", int'(done), 0);
      @(posedge clk);
      @(negedge clk);
      check("R5", "no extra done", int'(done), 0);
      check("R6", "f held", int'(f), ef);
      check("R6", "g held", int'(g), eg);
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", "reset done", int'(done), 0);
      check("R1", "reset f", int'(f), 0);
      check("R1", "reset g", int'(g), 0);
      rst_n = 1'b1;
      a = 8'd9; b = 8'd8; c = 8'd7; d = 8'd6; e = 8'd5;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         check("R1", "idle done", int'(done), 0);
      end

      // directed corners: wrapping sums and products
      run(8'd255, 8'd1,   8'd3,   8'd4,   8'd7,   1'b0, 1'b0);
      run(8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 1'b0, 1'b0);
      run(8'd200, 8'd100, 8'd250, 8'd10,  8'd3,   1'b1, 1'b1);
      run(8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   1'b1, 1'b0);
      run(8'd16,  8'd16,  8'd8,   8'd8,   8'd128, 1'b0, 1'b1);
      run(8'd1,   8'd2,   8'd3,   8'd4,   8'd5,   1'b1, 1'b1);

      // constrained random
      for (int k = 0; k < 60; k++) begin
         run(W'($urandom), W'($urandom), W'($urandom), W'($urandom), W'($urandom),
             1'($urandom), 1'($urandom));
         if (k % 7 == 3) begin
            for (int j = 0; j < 3; j++) begin
               @(negedge clk);
               check("R6", "idle done", int'(done), 0);
            end
         end
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule